// File: doc/BRIEF.md
# Credit-Controlled Static-Priority Memory Arbiter

This block decides which of N requestors may issue the next transaction to a shared memory. Each requestor is rate limited. On every clock cycle the arbiter keeps a per-requestor balance of service credit, called its potential, held in signed fixed point with 8 fractional bits. One service unit is 256 in this format. The balance is refilled by a configured rate while the requestor is active. Each grant debits the transaction's size from it.

Memory transactions cannot be interrupted. A requestor is therefore allowed to compete normally only when its balance already covers the whole transaction. Among those that qualify, a configured static priority picks the winner. If nobody qualifies but someone is waiting, the arbiter does not stay idle. It serves the highest-priority waiting requestor anyway.

Requests follow a valid/ready style. A requestor raises its `req_valid` bit and holds it, together with its size field, until it sees its own `grant` bit in the same cycle as `grant_valid`. That pulse is the acceptance, and the requestor may drop or renew its request after it. The memory side applies back-pressure simply by delaying `mem_done`. The grant stays on the bus until then, and nothing else is accepted in the meantime. Configuration pins are plain levels, meant to change only while the affected requestor is idle.

Top module: `ccsp_arbiter`

## Requirements
- R1: While a requestor is active, its potential rises by its rate (`cfg_rate`, 8 fractional bits, 256 = one unit per cycle) on every clock cycle.
- R2: A requestor is active while its `req_valid` is high or its potential is negative. On any inactive cycle its potential is reloaded with its burstiness offset `cfg_sigma` (8 fractional bits). A requestor in debt therefore keeps its debt after dropping its request.
- R3: A requestor qualifies only when its `req_valid` is high and its potential is at least its `req_size` (integer units) times 256.
- R4: When one or more requestors qualify, the qualifying requestor with the largest `cfg_prio` value is granted.
- R5: When requests are pending but none qualifies, the pending requestor with the largest `cfg_prio` value is granted.
- R6: Among equal priorities the lower requestor index wins.
- R7: On the clock edge that issues a grant, the granted requestor's potential is reduced by its size times 256, in addition to that cycle's rate increment.
- R8: `grant` is zero or one-hot. `grant_valid` is a one-cycle pulse, raised on the edge where `grant` changes from zero to the new one-hot value. The granted requestor was requesting in the cycle before.
- R9: A grant is held unchanged until `mem_done` is sampled high, and it is then cleared on that edge. No new grant is issued on the edge that samples `mem_done`, so the earliest next grant comes one edge later.
- R10: During and right after reset, `grant` and `grant_valid` are zero and all potentials are zero. Each potential loads its offset on its first inactive cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | N | Per-requestor request pending |
| req_size | input | N*SIZE_W | Per-requestor transaction cost in whole service units |
| cfg_sigma | input | N*SIG_W | Per-requestor burstiness offset, 8 fractional bits |
| cfg_rate | input | N*RATE_W | Per-requestor rate, 8 fractional bits |
| cfg_prio | input | N*PRIO_W | Per-requestor static priority, larger value wins |
| mem_done | input | 1 | Memory finished the granted transaction |
| grant | output | N | One-hot grant, held until `mem_done` |
| grant_valid | output | 1 | One-cycle strobe when a new grant is issued |

## Verification
The bound checker watches the grant protocol on every cycle. It checks that the grant is zero or one-hot, that the strobe is a single-cycle pulse issued only from an empty grant, that the winner was actually requesting, and that the grant is held until `mem_done` and then released. The credit rules cannot be seen from a single cycle, because they depend on accumulated history. These rules are: the growth by rate, the reload to the offset when inactive, the debt that survives a dropped request, and eligibility versus the work-conserving fallback. Only the bench scenarios can show them. Each scenario is built so that a wrong credit rule changes the order in which grants arrive.

// File: rtl/ccsp_pkg.sv
package ccsp_pkg;

  // Fractional bits of every rate, offset and potential value.
  localparam int unsigned FRAC_BITS = 8;

  typedef enum logic {
    ARB_IDLE = 1'b0,
    ARB_BUSY = 1'b1
  } arb_state_e;

endpackage

// File: rtl/ccsp_credit.sv
module ccsp_credit #(
  parameter int unsigned POT_W  = 20,
  parameter int unsigned SIG_W  = 16,
  parameter int unsigned RATE_W = 9,
  parameter int unsigned SIZE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic [SIZE_W-1:0] size,
  input  logic [SIG_W-1:0]  sigma,
  input  logic [RATE_W-1:0] rate,
  input  logic              charge,
  output logic              eligible
);
  import ccsp_pkg::*;

  localparam int unsigned COST_PAD = POT_W - SIZE_W - FRAC_BITS;
  localparam logic signed [POT_W:0] POT_MAX = {2'b00, {(POT_W-1){1'b1}}};
  localparam logic signed [POT_W:0] POT_MIN = {2'b11, {(POT_W-1){1'b0}}};

  logic signed [POT_W-1:0] pot;
  logic signed [POT_W-1:0] cost;
  logic signed [POT_W:0]   nxt;
  logic                    active;

  assign cost   = {{COST_PAD{1'b0}}, size, {FRAC_BITS{1'b0}}};
  assign active = req | pot[POT_W-1];

  // One extra bit of headroom, then saturate in both directions.
  assign nxt = {pot[POT_W-1], pot}
             + {{(POT_W+1-RATE_W){1'b0}}, rate}
             - (charge ? {1'b0, cost} : {(POT_W+1){1'b0}});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pot <= '0;
    end else if (!active) begin
      pot <= {{(POT_W-SIG_W){1'b0}}, sigma};
    end else if (nxt > POT_MAX) begin
      pot <= POT_MAX[POT_W-1:0];
    end else if (nxt < POT_MIN) begin
      pot <= POT_MIN[POT_W-1:0];
    end else begin
      pot <= nxt[POT_W-1:0];
    end
  end

  assign eligible = req && (pot >= cost);

endmodule

// File: rtl/ccsp_pick.sv
module ccsp_pick #(
  parameter int unsigned N      = 4,
  parameter int unsigned PRIO_W = 2
) (
  input  logic [N-1:0]        mask,
  input  logic [N*PRIO_W-1:0] prio,
  output logic                found,
  output logic [N-1:0]        onehot
);

  logic [PRIO_W-1:0] best;

  // Strictly-greater comparison keeps the lower index on a tie.
  always_comb begin
    found  = 1'b0;
    best   = '0;
    onehot = '0;
    for (int i = 0; i < N; i++) begin
      if (mask[i] && (!found || prio[i*PRIO_W +: PRIO_W] > best)) begin
        found     = 1'b1;
        best      = prio[i*PRIO_W +: PRIO_W];
        onehot    = '0;
        onehot[i] = 1'b1;
      end
    end
  end

endmodule

// File: rtl/ccsp_arbiter.sv
module ccsp_arbiter #(
  parameter int unsigned N      = 4,
  parameter int unsigned SIZE_W = 4,
  parameter int unsigned SIG_W  = 16,
  parameter int unsigned RATE_W = 9,
  parameter int unsigned PRIO_W = 2,
  parameter int unsigned POT_W  = 20
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N-1:0]        req_valid,
  input  logic [N*SIZE_W-1:0] req_size,
  input  logic [N*SIG_W-1:0]  cfg_sigma,
  input  logic [N*RATE_W-1:0] cfg_rate,
  input  logic [N*PRIO_W-1:0] cfg_prio,
  input  logic                mem_done,
  output logic [N-1:0]        grant,
  output logic                grant_valid
);
  import ccsp_pkg::*;

  arb_state_e   state;
  logic [N-1:0] elig;
  logic [N-1:0] pick_elig;
  logic [N-1:0] pick_any;
  logic [N-1:0] winner;
  logic [N-1:0] charge;
  logic         found_elig;
  logic         found_any;
  logic         launch;

  for (genvar g = 0; g < N; g++) begin : g_credit
    ccsp_credit #(
      .POT_W  (POT_W),
      .SIG_W  (SIG_W),
      .RATE_W (RATE_W),
      .SIZE_W (SIZE_W)
    ) u_credit (
      .clk      (clk),
      .rst_n    (rst_n),
      .req      (req_valid[g]),
      .size     (req_size[g*SIZE_W +: SIZE_W]),
      .sigma    (cfg_sigma[g*SIG_W +: SIG_W]),
      .rate     (cfg_rate[g*RATE_W +: RATE_W]),
      .charge   (charge[g]),
      .eligible (elig[g])
    );
  end

  ccsp_pick #(.N(N), .PRIO_W(PRIO_W)) u_pick_elig (
    .mask   (elig),
    .prio   (cfg_prio),
    .found  (found_elig),
    .onehot (pick_elig)
  );

  ccsp_pick #(.N(N), .PRIO_W(PRIO_W)) u_pick_any (
    .mask   (req_valid),
    .prio   (cfg_prio),
    .found  (found_any),
    .onehot (pick_any)
  );

  // Qualified requestors first; otherwise fall back to any pending one.
  assign winner = found_elig ? pick_elig : pick_any;
  assign launch = (state == ARB_IDLE) && found_any;
  assign charge = launch ? winner : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ARB_IDLE;
      grant       <= '0;
      grant_valid <= 1'b0;
    end else begin
      grant_valid <= 1'b0;
      case (state)
        ARB_IDLE: begin
          if (launch) begin
            grant       <= winner;
            grant_valid <= 1'b1;
            state       <= ARB_BUSY;
          end
        end
        ARB_BUSY: begin
          if (mem_done) begin
            grant <= '0;
            state <= ARB_IDLE;
          end
        end
        default: state <= ARB_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/ccsp_arbiter_chk.sv
module ccsp_arbiter_chk #(
  parameter int unsigned N = 4
) (
  input logic         clk,
  input logic         rst_n,
  input logic [N-1:0] req_valid,
  input logic         mem_done,
  input logic [N-1:0] grant,
  input logic         grant_valid
);

  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant)); // R8

  AST_STROBE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid |=> !grant_valid); // R8

  AST_STROBE_FROM_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid |-> ($past(grant) == '0 && $countones(grant) == 1)); // R8

  AST_WINNER_REQUESTED: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid |-> (($past(req_valid) & grant) != '0)); // R8

  AST_GRANT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (grant != '0 && !mem_done) |=> $stable(grant)); // R9

  AST_GRANT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (grant != '0 && mem_done) |=> (grant == '0 && !grant_valid)); // R9

endmodule

bind ccsp_arbiter ccsp_arbiter_chk #(.N(N)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .mem_done    (mem_done),
  .grant       (grant),
  .grant_valid (grant_valid)
);

// File: tb/ccsp_arbiter_tb.sv
`timescale 1ns/1ps
module ccsp_arbiter_tb;
  localparam int N      = 4;
  localparam int SIZE_W = 4;
  localparam int SIG_W  = 16;
  localparam int RATE_W = 9;
  localparam int PRIO_W = 2;

  logic                clk = 1'b0;
  logic                rst_n;
  logic [N-1:0]        req_valid;
  logic [N*SIZE_W-1:0] req_size;
  logic [N*SIG_W-1:0]  cfg_sigma;
  logic [N*RATE_W-1:0] cfg_rate;
  logic [N*PRIO_W-1:0] cfg_prio;
  logic                mem_done;
  logic [N-1:0]        grant;
  logic                grant_valid;

  always #2.5 clk = ~clk;

  ccsp_arbiter #(
    .N(N), .SIZE_W(SIZE_W), .SIG_W(SIG_W), .RATE_W(RATE_W), .PRIO_W(PRIO_W)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_size(req_size),
    .cfg_sigma(cfg_sigma), .cfg_rate(cfg_rate), .cfg_prio(cfg_prio),
    .mem_done(mem_done), .grant(grant), .grant_valid(grant_valid)
  );

  int           exp_q[$];
  int           vectors = 0;
  int           errors  = 0;
  int           cyc     = 0;
  int           cnt     = 0;
  int           done_dly = 0;
  int           rerq_left[N];
  logic [N-1:0] prev_grant = '0;

  task automatic fail(string tag, int act, int exp);
    errors++;
    $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
  endtask

  task automatic check(bit ok, string tag, int act, int exp);
    vectors++;
    if (!ok) fail(tag, act, exp);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  endtask

  function automatic int idx_of(logic [N-1:0] g);
    for (int i = 0; i < N; i++) if (g[i]) return i;
    return -1;
  endfunction

  task automatic expect_grant(int idx);
    exp_q.push_back(idx);
  endtask

  // One clock of driver + monitor + memory responder, run at the falling edge.
  task automatic step();
    logic done_seen;
    int   got;
    int   want;
    @(negedge clk);
    cyc++;
    done_seen = mem_done;
    mem_done  = 1'b0;
    if (cyc > 100000) begin
      fail("watchdog", cyc, 0);
      finish_run();
    end
    if (prev_grant != '0 && !done_seen) begin
      check(grant == prev_grant, "R9 grant held", int'(grant), int'(prev_grant));
    end
    if (grant_valid) begin
      check(prev_grant == '0, "R9 no grant while busy", int'(prev_grant), 0);
      check($countones(grant) == 1, "R8 one-hot", int'(grant), 1);
      got = idx_of(grant);
      if (exp_q.size() == 0) begin
        vectors++;
        fail("R4 unexpected grant", got, -1);
      end else begin
        want = exp_q.pop_front();
        check(got == want, "R4/R5 grant order", got, want);
      end
      if (got >= 0) begin
        if (rerq_left[got] > 0) rerq_left[got]--;
        else req_valid[got] = 1'b0;
      end
      if (done_dly == 0) mem_done = 1'b1;
      else cnt = done_dly;
    end else if (cnt > 0) begin
      cnt--;
      if (cnt == 0) mem_done = 1'b1;
    end
    prev_grant = grant;
  endtask

  task automatic set_cfg(int i, int sig, int rate, int pr, int sz);
    cfg_sigma[i*SIG_W +: SIG_W]    = SIG_W'(sig);
    cfg_rate[i*RATE_W +: RATE_W]   = RATE_W'(rate);
    cfg_prio[i*PRIO_W +: PRIO_W]   = PRIO_W'(pr);
    req_size[i*SIZE_W +: SIZE_W]   = SIZE_W'(sz);
  endtask

  task automatic wait_idle();
    while (exp_q.size() != 0 || grant != '0 || req_valid != '0 || cnt != 0 || mem_done)
      step();
    repeat (4) step();
  endtask

  task automatic wait_drained();
    while (exp_q.size() != 0) step();
  endtask

  initial begin
    rst_n     = 1'b0;
    req_valid = '0;
    req_size  = '0;
    cfg_sigma = '0;
    cfg_rate  = '0;
    cfg_prio  = '0;
    mem_done  = 1'b0;
    for (int i = 0; i < N; i++) rerq_left[i] = 0;
    repeat (3) @(negedge clk);
    // R10: outputs quiet during reset
    check(grant == '0, "R10 grant in reset", int'(grant), 0);
    check(grant_valid == 1'b0, "R10 strobe in reset", int'(grant_valid), 0);
    rst_n = 1'b1;
    step();
    check(grant == '0 && !grant_valid, "R10 after reset", int'(grant), 0);

    // R4: all qualify, priority values {1,3,2,0} -> order 1,2,0,3
    done_dly = 3;
    set_cfg(0, 4096, 32, 1, 1);
    set_cfg(1, 4096, 32, 3, 1);
    set_cfg(2, 4096, 32, 2, 1);
    set_cfg(3, 4096, 32, 0, 1);
    repeat (3) step();
    expect_grant(1); expect_grant(2); expect_grant(0); expect_grant(3);
    req_valid = 4'b1111;
    wait_idle();

    // R6: priorities {2,0,2,0} -> ties resolved by lower index: 0,2,1,3
    done_dly = 1;
    set_cfg(0, 4096, 32, 2, 1);
    set_cfg(1, 4096, 32, 0, 1);
    set_cfg(2, 4096, 32, 2, 1);
    set_cfg(3, 4096, 32, 0, 1);
    repeat (3) step();
    expect_grant(0); expect_grant(2); expect_grant(1); expect_grant(3);
    req_valid = 4'b1111;
    wait_idle();

    // R1/R3: req1 (prio 3, sigma 0, rate 0.25, size 1) must wait for
    // its potential to reach 256: low-priority req3 wins twice first.
    done_dly = 0;
    set_cfg(0, 0, 0, 0, 1);
    set_cfg(1, 0, 64, 3, 1);
    set_cfg(2, 0, 0, 0, 1);
    set_cfg(3, 4096, 64, 0, 1);
    repeat (3) step();
    rerq_left[3] = 1;
    expect_grant(3); expect_grant(3); expect_grant(1);
    req_valid = 4'b1010;
    wait_idle();

    // R2/R3: req0 offset is exactly one unit; after idling it holds
    // only that much, so its back-to-back second request loses to req3.
    set_cfg(0, 256, 64, 3, 1);
    set_cfg(1, 0, 0, 0, 1);
    set_cfg(3, 4096, 64, 0, 1);
    repeat (40) step();
    rerq_left[0] = 1;
    expect_grant(0); expect_grant(3); expect_grant(0);
    req_valid = 4'b1001;
    wait_idle();

    // R5/R7: req1 (offset 2 units, size 4) alone is served by fallback and
    // goes into debt; with size 1 next time it still loses to req3 (R2).
    set_cfg(0, 0, 0, 0, 1);
    set_cfg(1, 512, 64, 3, 4);
    set_cfg(3, 4096, 64, 0, 1);
    repeat (3) step();
    expect_grant(1);
    req_valid = 4'b0010;
    wait_drained();
    step();
    req_size[1*SIZE_W +: SIZE_W] = SIZE_W'(1);
    expect_grant(3); expect_grant(1);
    req_valid = 4'b1010;
    wait_idle();

    check(exp_q.size() == 0, "R8 all expected grants seen", exp_q.size(), 0);
    finish_run();
  end

endmodule